// File: doc/BRIEF.md
# Sliding-Window Recursion Sequencer

This block drives a single time-shared log-domain trellis decoder that works on a frame in sliding windows. After a start pulse it walks every window of the frame through three phases: a forward sweep from the window's first stage to its last, a warm-up sweep that begins past the window's end and walks back toward it, and a backward sweep from the window's end back to its start. The block issues the trellis stage index and a phase code. It also issues a read strobe at the start of each stage, a metric-store strobe at the end of each forward stage and an extrinsic-write strobe at the end of each backward stage.

Every stage holds for a fixed number of clock cycles. That number is set by the code shape: `2^(IN_BITS-1)*(IN_BITS+PARITY_BITS) + 4*(2^IN_BITS-1) + 1`, which gives 7 for one input bit and one parity bit. The whole frame is decoded the requested number of times, and each decode of the frame is one pass. Successive passes swap the decoder between its upper and lower component roles. A frame of 128 stages or fewer is handled as a single window with no warm-up. The configuration is captured when a decode is accepted, and a done pulse marks the end of the final pass.

Top module: `swseq_top`

## Requirements
- R1: While reset is high and on the cycle after it, phase is 0, stage is 0, the pass index is 0, the role is 0 and done and all three strobes are low.
- R2: Each stage index holds for exactly STAGE_CYC cycles. `stage_rd` is high on the first of those cycles only. `metric_wr` is high on the last cycle of a forward stage only, and `ext_wr` is high on the last cycle of a backward stage only.
- R3: Phase codes are 0 idle, 1 forward, 2 warm-up and 3 backward. The first busy cycle follows the cycle in which start is sampled. The windows begin at stage 0 and each holds `win_len` stages, except the last, which holds the remainder. For a window [s,e], the forward sweep visits s up to e, the warm-up (if any) comes next, and the backward sweep then visits e down to s.
- R4: Every window except the last gets a warm-up over stages min(e+`warm_len`, N-1) down to e+1, in phase 2. The last window gets none, and no window gets one when `warm_len` is 0.
- R5: When `frame_len` is 128 or less, the frame is one window of `frame_len` stages with no warm-up, whatever `win_len` and `warm_len` hold.
- R6: Passes run back to back with no gap, and `pass_idx` counts 0 up to `num_passes`-1. `role` equals bit 0 of the pass index: 0 is upper and 1 is lower.
- R7: On the cycle after the last backward stage of the final pass, `done` is high for exactly one cycle. On that cycle the phase is 0 and the pass index is 0.
- R8: A start pulse sampled while the phase is not 0 has no effect, and neither does any change to the configuration inputs during a decode.
- R9: A start pulse is ignored when `frame_len` is 0, when `num_passes` is 0, or when the frame is longer than 128 and `win_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a decode |
| frame_len | input | FRAME_W | Trellis stages per frame (N) |
| win_len | input | FRAME_W | Window length for long frames |
| warm_len | input | FRAME_W | Warm-up length for long frames |
| num_passes | input | PASS_W | Number of passes (B) |
| phase | output | 2 | 0 idle, 1 forward, 2 warm-up, 3 backward |
| stage | output | FRAME_W | Current trellis stage index |
| pass_idx | output | PASS_W | Index of the current pass |
| role | output | 1 | 0 upper decoder, 1 lower decoder |
| stage_rd | output | 1 | First cycle of a stage |
| metric_wr | output | 1 | Last cycle of a forward stage |
| ext_wr | output | 1 | Last cycle of a backward stage |
| done | output | 1 | One-cycle end-of-decode pulse |

## Verification
The end of a final pass and the acceptance of a new decode can fall in the same cycle: the done cycle is idle, so a start sampled in that cycle must launch the next decode immediately. The bench raises start in the done cycle of one run with a new configuration. It then expects forward stage 0 of pass 0 of that new frame on the very next cycle, and the clamped, shortened warm-up of its second window later on. A start pulse with a different configuration is also injected in the middle of a run, and the cycle-exact trace must stay the one computed for the original configuration.

// File: rtl/swseq_pkg.sv
package swseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FWD  = 2'd1,
        PH_PBW  = 2'd2,
        PH_BWD  = 2'd3
    } phase_e;

    // Frames up to this length bypass windowing.
    localparam int unsigned SHORT_FRAME_MAX = 128;

    // Cycles per trellis stage: additions, max* steps and one idle slot.
    function automatic int unsigned stage_cycles(input int unsigned in_bits,
                                                 input int unsigned par_bits);
        return ((1 << (in_bits - 1)) * (in_bits + par_bits))
             + 4 * ((1 << in_bits) - 1) + 1;
    endfunction

endpackage

// File: rtl/swseq_cfg.sv
module swseq_cfg
    import swseq_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int PASS_W  = 8
) (
    input  logic [FRAME_W-1:0] frame_len,
    input  logic [FRAME_W-1:0] win_len,
    input  logic [FRAME_W-1:0] warm_len,
    input  logic [PASS_W-1:0]  num_passes,
    output logic               cfg_ok,
    output logic [FRAME_W-1:0] eff_win,
    output logic [FRAME_W-1:0] eff_warm
);
    localparam logic [FRAME_W:0] SHORT_LIM = (FRAME_W+1)'(SHORT_FRAME_MAX);

    logic is_short;

    always_comb begin
        is_short = ({1'b0, frame_len} <= SHORT_LIM);
        eff_win  = is_short ? frame_len : win_len;
        eff_warm = is_short ? '0 : warm_len;
        cfg_ok   = (frame_len != '0) && (num_passes != '0) && (eff_win != '0);
    end
endmodule

// File: rtl/swseq_pace.sv
module swseq_pace #(
    parameter int STAGE_CYC = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic first,
    output logic last
);
    localparam int CNT_W = (STAGE_CYC < 2) ? 1 : $clog2(STAGE_CYC);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STAGE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        first = run && (cnt_q == '0);
        last  = run && (cnt_q == CNT_MAX);
    end
endmodule

// File: rtl/swseq_walker.sv
module swseq_walker
    import swseq_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int PASS_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               step,
    input  logic [FRAME_W-1:0] frame_len,
    input  logic [FRAME_W-1:0] eff_win,
    input  logic [FRAME_W-1:0] eff_warm,
    input  logic [PASS_W-1:0]  num_passes,
    output phase_e             phase,
    output logic [FRAME_W-1:0] stage,
    output logic [PASS_W-1:0]  pass_idx,
    output logic               done
);
    typedef struct packed {
        phase_e             ph;
        logic [FRAME_W-1:0] stg;
        logic [FRAME_W-1:0] wbeg;
        logic [FRAME_W-1:0] wend;
        logic [PASS_W-1:0]  pas;
        logic               dn;
    } walk_t;

    walk_t cur, nxt;

    // Configuration captured on acceptance.
    logic [FRAME_W-1:0] n_last_q, win_q, warm_q;
    logic [PASS_W-1:0]  pmax_q;

    function automatic logic [FRAME_W-1:0] clip(input logic [FRAME_W:0]   v,
                                                 input logic [FRAME_W-1:0] lim);
        return (v > {1'b0, lim}) ? lim : v[FRAME_W-1:0];
    endfunction

    logic is_last_win, has_warm;

    always_comb begin
        is_last_win = (cur.wend == n_last_q);
        has_warm    = !is_last_win && (warm_q != '0);
        nxt         = cur;
        nxt.dn      = 1'b0;
        unique case (cur.ph)
            PH_IDLE: begin
                if (accept) begin
                    nxt.ph   = PH_FWD;
                    nxt.stg  = '0;
                    nxt.wbeg = '0;
                    nxt.wend = clip({1'b0, eff_win} - (FRAME_W+1)'(1),
                                    frame_len - FRAME_W'(1));
                    nxt.pas  = '0;
                end
            end
            PH_FWD: begin
                if (step) begin
                    if (cur.stg == cur.wend) begin
                        if (has_warm) begin
                            nxt.ph  = PH_PBW;
                            nxt.stg = clip({1'b0, cur.wend} + {1'b0, warm_q},
                                           n_last_q);
                        end else begin
                            nxt.ph  = PH_BWD;
                        end
                    end else begin
                        nxt.stg = cur.stg + FRAME_W'(1);
                    end
                end
            end
            PH_PBW: begin
                if (step) begin
                    if (cur.stg == cur.wend + FRAME_W'(1)) begin
                        nxt.ph  = PH_BWD;
                        nxt.stg = cur.wend;
                    end else begin
                        nxt.stg = cur.stg - FRAME_W'(1);
                    end
                end
            end
            PH_BWD: begin
                if (step) begin
                    if (cur.stg != cur.wbeg) begin
                        nxt.stg = cur.stg - FRAME_W'(1);
                    end else if (!is_last_win) begin
                        nxt.ph   = PH_FWD;
                        nxt.wbeg = cur.wend + FRAME_W'(1);
                        nxt.stg  = cur.wend + FRAME_W'(1);
                        nxt.wend = clip({1'b0, cur.wend} + {1'b0, win_q},
                                        n_last_q);
                    end else if (cur.pas == pmax_q) begin
                        nxt.ph   = PH_IDLE;
                        nxt.stg  = '0;
                        nxt.wbeg = '0;
                        nxt.wend = '0;
                        nxt.pas  = '0;
                        nxt.dn   = 1'b1;
                    end else begin
                        nxt.ph   = PH_FWD;
                        nxt.pas  = cur.pas + PASS_W'(1);
                        nxt.stg  = '0;
                        nxt.wbeg = '0;
                        nxt.wend = clip({1'b0, win_q} - (FRAME_W+1)'(1),
                                        n_last_q);
                    end
                end
            end
            default: nxt = cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '{ph: PH_IDLE, default: '0};
            n_last_q <= '0;
            win_q    <= '0;
            warm_q   <= '0;
            pmax_q   <= '0;
        end else begin
            cur <= nxt;
            if (accept && (cur.ph == PH_IDLE)) begin
                n_last_q <= frame_len - FRAME_W'(1);
                win_q    <= eff_win;
                warm_q   <= eff_warm;
                pmax_q   <= num_passes - PASS_W'(1);
            end
        end
    end

    always_comb begin
        phase    = cur.ph;
        stage    = cur.stg;
        pass_idx = cur.pas;
        done     = cur.dn;
    end
endmodule

// File: rtl/swseq_top.sv
module swseq_top
    import swseq_pkg::*;
#(
    parameter int FRAME_W     = 16,
    parameter int PASS_W      = 8,
    parameter int IN_BITS     = 1,
    parameter int PARITY_BITS = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_len,
    input  logic [FRAME_W-1:0] win_len,
    input  logic [FRAME_W-1:0] warm_len,
    input  logic [PASS_W-1:0]  num_passes,
    output logic [1:0]         phase,
    output logic [FRAME_W-1:0] stage,
    output logic [PASS_W-1:0]  pass_idx,
    output logic               role,
    output logic               stage_rd,
    output logic               metric_wr,
    output logic               ext_wr,
    output logic               done
);
    localparam int STAGE_CYC = int'(stage_cycles(IN_BITS, PARITY_BITS));

    logic               cfg_ok;
    logic [FRAME_W-1:0] eff_win, eff_warm;
    logic               accept;
    logic               stage_first, stage_last;
    phase_e             ph;

    swseq_cfg #(.FRAME_W(FRAME_W), .PASS_W(PASS_W)) u_cfg (
        .frame_len (frame_len),
        .win_len   (win_len),
        .warm_len  (warm_len),
        .num_passes(num_passes),
        .cfg_ok    (cfg_ok),
        .eff_win   (eff_win),
        .eff_warm  (eff_warm)
    );

    swseq_pace #(.STAGE_CYC(STAGE_CYC)) u_pace (
        .clk  (clk),
        .rst  (rst),
        .run  (ph != PH_IDLE),
        .first(stage_first),
        .last (stage_last)
    );

    assign accept = start && cfg_ok && (ph == PH_IDLE);

    swseq_walker #(.FRAME_W(FRAME_W), .PASS_W(PASS_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .step      (stage_last),
        .frame_len (frame_len),
        .eff_win   (eff_win),
        .eff_warm  (eff_warm),
        .num_passes(num_passes),
        .phase     (ph),
        .stage     (stage),
        .pass_idx  (pass_idx),
        .done      (done)
    );

    always_comb begin
        phase     = ph;
        role      = pass_idx[0];
        stage_rd  = stage_first;
        metric_wr = stage_last && (ph == PH_FWD);
        ext_wr    = stage_last && (ph == PH_BWD);
    end
endmodule

// File: rtl/swseq_checker.sv
module swseq_checker #(
    parameter int FRAME_W = 16,
    parameter int PASS_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [1:0]         phase,
    input logic [FRAME_W-1:0] stage,
    input logic [PASS_W-1:0]  pass_idx,
    input logic               role,
    input logic               done,
    input logic               stage_last
);
    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0 && !stage_last) |=> ($stable(stage) && $stable(phase)));

    assert_fwd_stays_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1) |=> (phase != 2'd0));

    assert_warm_then_bwd_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2) |=> (phase == 2'd2 || phase == 2'd3));

    assert_role_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0 && !(phase == 2'd3 && stage_last)) |=> $stable(role));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == 2'd0 && pass_idx == '0));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0 && start && !stage_last) |=> ($stable(pass_idx) && $stable(phase)));
endmodule

bind swseq_top swseq_checker #(.FRAME_W(FRAME_W), .PASS_W(PASS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .phase     (phase),
    .stage     (stage),
    .pass_idx  (pass_idx),
    .role      (role),
    .done      (done),
    .stage_last(stage_last)
);

// File: tb/swseq_top_test.sv
module swseq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 16;
    localparam int PW = 8;
    localparam int KB = 1;
    localparam int NB = 1;
    localparam int SC = (1 << (KB - 1)) * (KB + NB) + 4 * ((1 << KB) - 1) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [FW-1:0] frame_len = '0, win_len = '0, warm_len = '0;
    logic [PW-1:0] num_passes = '0;
    logic [1:0]    phase;
    logic [FW-1:0] stage;
    logic [PW-1:0] pass_idx;
    logic          role, stage_rd, metric_wr, ext_wr, done;

    int nchecks = 0;
    int nfail   = 0;
    int cyc     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swseq_top #(.FRAME_W(FW), .PASS_W(PW), .IN_BITS(KB), .PARITY_BITS(NB)) uut (
        .clk(clk), .rst(rst), .start(start),
        .frame_len(frame_len), .win_len(win_len), .warm_len(warm_len),
        .num_passes(num_passes),
        .phase(phase), .stage(stage), .pass_idx(pass_idx), .role(role),
        .stage_rd(stage_rd), .metric_wr(metric_wr), .ext_wr(ext_wr), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            if (nfail < 30)
                $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_stage(input int ph, input int idx, input int p,
                            input bit short_f, input int ignore_at);
        string tag;
        tag = short_f ? "R5" : ((ph == 2) ? "R4" : "R3");
        for (int c = 0; c < SC; c++) begin
            chk(tag, int'(phase), ph);
            chk(tag, int'(stage), idx);
            chk("R6 pass", int'(pass_idx), p);
            chk("R6 role", int'(role), p % 2);
            chk("R2 rd", int'(stage_rd), (c == 0) ? 1 : 0);
            chk("R2 mwr", int'(metric_wr), (c == SC - 1 && ph == 1) ? 1 : 0);
            chk("R2 ewr", int'(ext_wr), (c == SC - 1 && ph == 3) ? 1 : 0);
            chk("R7 no done", int'(done), 0);
            if (ignore_at >= 0) begin
                if (cyc == ignore_at) begin
                    // R8: start with other config while busy
                    start = 1'b1;
                    frame_len = 16'd3;
                    win_len = 16'd1;
                    num_passes = 8'd1;
                end else begin
                    start = 1'b0;
                end
            end
            cyc++;
            @(negedge clk);
        end
    endtask

    // Starts at a negedge; returns at the negedge of the done cycle.
    task automatic run_decode(input int n, input int wcfg, input int pcfg,
                              input int b, input int ignore_at);
        int ws, wp, s, e, hi;
        bit short_f;
        frame_len = FW'(n);
        win_len = FW'(wcfg);
        warm_len = FW'(pcfg);
        num_passes = PW'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        short_f = (n <= 128);
        ws = short_f ? n : wcfg;
        wp = short_f ? 0 : pcfg;
        for (int p = 0; p < b; p++) begin
            s = 0;
            while (s < n) begin
                e = ((s + ws < n) ? s + ws : n) - 1;
                for (int i = s; i <= e; i++) do_stage(1, i, p, short_f, ignore_at);
                if (e != n - 1 && wp > 0) begin
                    hi = (e + wp < n - 1) ? e + wp : n - 1;
                    for (int i = hi; i > e; i--) do_stage(2, i, p, short_f, ignore_at);
                end
                for (int i = e; i >= s; i--) do_stage(3, i, p, short_f, ignore_at);
                s = e + 1;
            end
        end
        start = 1'b0;
        chk("R7 done", int'(done), 1);
        chk("R7 idle", int'(phase), 0);
        chk("R7 pass0", int'(pass_idx), 0);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk("R7 pulse", int'(done), 0);
        chk("R7 stay idle", int'(phase), 0);
    endtask

    task automatic bad_start(input int n, input int wcfg, input int b);
        frame_len = FW'(n);
        win_len = FW'(wcfg);
        warm_len = 16'd4;
        num_passes = PW'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R9 idle", int'(phase), 0);
            chk("R9 no done", int'(done), 0);
            chk("R9 no rd", int'(stage_rd), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 phase", int'(phase), 0);
        chk("R1 stage", int'(stage), 0);
        chk("R1 pass", int'(pass_idx), 0);
        chk("R1 role", int'(role), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 strobes", int'({stage_rd, metric_wr, ext_wr}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after", int'(phase), 0);
        chk("R1 after rd", int'(stage_rd), 0);

        bad_start(0, 8, 1);
        bad_start(6, 8, 0);
        bad_start(200, 0, 1);

        run_decode(5, 128, 24, 4, -1);
        after_done();
        run_decode(128, 10, 24, 2, -1);
        after_done();
        run_decode(129, 128, 24, 1, -1);
        // start in the done cycle: accepted at once
        run_decode(140, 64, 24, 3, 50);
        after_done();
        run_decode(300, 128, 24, 2, -1);
        after_done();
        run_decode(1, 5, 5, 1, -1);
        after_done();

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule